// File: doc/BRIEF.md
# Sensor Reading Register Bank with Coherent Byte Snapshot

This block is the byte-wide register file that sits between the host's serial-bus slave logic and a measurement engine. The host side sees a simple parallel port: an 8-bit address, write data, a write strobe, a read strobe and registered read data. On the measurement side, each channel has an update strobe. The strobe delivers a fresh two-byte reading at any moment, with no relation to host activity.

A reading is wider than one bus transfer, so the host must fetch its two bytes in two reads. To keep the pair consistent, a host read of a channel's high byte returns the live high byte. On that same clock edge it freezes the matching low byte into a holding register. A later low-byte read returns the frozen value, even if a new conversion has arrived in between. The bank also keeps a configuration register with separate read and write addresses, a status register loaded by the measurement engine, a write-only one-shot command that emits a conversion-request pulse, one correction factor per remote channel, and read-only identification bytes. The product identifier is chosen by a parameter.

Top module: `sensbank_top`

## Requirements
- R1: After reset, every temperature byte, the status register and the configuration register read 00h, and each correction-factor register reads 12h.
- R2: A read of an address with no readable register returns 00h. This includes the write-only addresses 09h and 0Fh.
- R3: A write to an address with no writable register changes no readable value and no output.
- R4: For channel c, the high byte is at address 10h+2c and the low byte at 11h+2c. A high-byte read returns the live high byte and, on the same edge, captures the live low byte. A following low-byte read returns that captured byte, even if an update arrived after the high-byte read.
- R5: A low-byte read with no earlier high-byte read returns the current holding-register content and does not capture anything. Out of reset, that content is 00h.
- R6: When a channel update and a high-byte read of that channel fall in the same cycle, both bytes returned come from the reading that was live before the update.
- R7: The configuration register is written at 09h and read at 03h. Its value also drives the cfg_out port from the edge that follows the write.
- R8: The status register reads at 02h. It is loaded from stat_in when stat_we is high, and host writes to 02h leave it unchanged.
- R9: A host write to 0Fh raises conv_req for exactly one cycle, starting at the edge that takes the write. The command stores no readable value.
- R10: The correction factors are read and written at 27h (remote channel 1) and 28h (remote channel 2), and they appear on corr_out, with channel 1 in bits 7:0.
- R11: Address FDh reads the PRODUCT_ID parameter, FEh reads 5Dh and FFh reads 01h. Host writes to these addresses change none of them.
- R12: rdata takes the addressed value on the clock edge where rd_en is sampled high, and it holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, loads all defaults |
| addr | input | 8 | Host register address |
| wdata | input | 8 | Host write data |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| rdata | output | 8 | Registered host read data |
| upd_valid | input | NUM_CH | Per-channel new-reading strobe |
| upd_hi | input | 8*NUM_CH | New high bytes, channel c in bits 8c+7:8c |
| upd_lo | input | 8*NUM_CH | New low bytes, same packing |
| stat_we | input | 1 | Status load strobe from the measurement engine |
| stat_in | input | 8 | Status value to load |
| cfg_out | output | 8 | Current configuration value |
| corr_out | output | 8*(NUM_CH-1) | Correction factors, remote channel r+1 in bits 8r+7:8r |
| conv_req | output | 1 | One-cycle conversion request |

## Verification
A read sweep over all 256 addresses is run straight out of reset. It is repeated after writing a marker byte to every address that has no writable register. Together the two sweeps separate a correct decode from a decode that aliases or lets a stray write land, and they cover both the default and the unmapped-address cases. The snapshot path is tested with three orderings. In the first, low is read before high, which shows the stale holding value. In the second, high is read, then an update arrives, then low is read, which shows the freeze. In the third, the update and the high-byte read share a cycle, which shows that the capture takes the value live before the edge. Distinct byte values per channel expose any cross-channel mix-up. Writes to read-only, split-address and one-shot locations are each followed by readbacks and output checks.

// File: rtl/sensbank_pkg.sv
package sensbank_pkg;

    localparam int unsigned DW = 8;

    localparam logic [7:0] A_STATUS    = 8'h02;
    localparam logic [7:0] A_CFG_RD    = 8'h03;
    localparam logic [7:0] A_CFG_WR    = 8'h09;
    localparam logic [7:0] A_ONESHOT   = 8'h0F;
    localparam logic [7:0] A_TEMP_BASE = 8'h10;
    localparam logic [7:0] A_CORR_BASE = 8'h27;
    localparam logic [7:0] A_PID       = 8'hFD;
    localparam logic [7:0] A_MID       = 8'hFE;
    localparam logic [7:0] A_REV       = 8'hFF;

    localparam logic [7:0] MID_VAL     = 8'h5D;
    localparam logic [7:0] REV_VAL     = 8'h01;
    localparam logic [7:0] CORR_DEF    = 8'h12;

    typedef struct packed {
        logic [DW-1:0] live_hi;
        logic [DW-1:0] live_lo;
        logic [DW-1:0] hold_lo;
    } chan_st_t;

endpackage

// File: rtl/sensbank_chan.sv
module sensbank_chan
    import sensbank_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd_valid,
    input  logic [DW-1:0] upd_hi,
    input  logic [DW-1:0] upd_lo,
    input  logic          cap,
    output logic [DW-1:0] live_hi,
    output logic [DW-1:0] hold_lo
);

    chan_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // capture uses the pre-edge live value, so a same-cycle update is not seen
        if (cap) begin
            st_d.hold_lo = st_q.live_lo;
        end
        if (upd_valid) begin
            st_d.live_hi = upd_hi;
            st_d.live_lo = upd_lo;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign live_hi = st_q.live_hi;
    assign hold_lo = st_q.hold_lo;

endmodule

// File: rtl/sensbank_ctl.sv
module sensbank_ctl
    import sensbank_pkg::*;
#(
    parameter int unsigned NUM_REMOTE = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [7:0]               addr,
    input  logic [DW-1:0]            wdata,
    input  logic                     wr_en,
    input  logic                     stat_we,
    input  logic [DW-1:0]            stat_in,
    output logic [DW-1:0]            cfg,
    output logic [DW-1:0]            status,
    output logic [NUM_REMOTE*DW-1:0] corr,
    output logic                     conv_req
);

    typedef struct packed {
        logic [DW-1:0]            cfg;
        logic [DW-1:0]            status;
        logic [NUM_REMOTE*DW-1:0] corr;
        logic                     conv_req;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.conv_req = wr_en && (addr == A_ONESHOT);
        if (wr_en && (addr == A_CFG_WR)) begin
            st_d.cfg = wdata;
        end
        for (int r = 0; r < int'(NUM_REMOTE); r++) begin
            if (wr_en && (addr == A_CORR_BASE + 8'(r))) begin
                st_d.corr[r*DW +: DW] = wdata;
            end
        end
        if (stat_we) begin
            st_d.status = stat_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cfg      <= '0;
            st_q.status   <= '0;
            st_q.corr     <= {NUM_REMOTE{CORR_DEF}};
            st_q.conv_req <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg      = st_q.cfg;
    assign status   = st_q.status;
    assign corr     = st_q.corr;
    assign conv_req = st_q.conv_req;

endmodule

// File: rtl/sensbank_top.sv
module sensbank_top
    import sensbank_pkg::*;
#(
    parameter int unsigned NUM_CH     = 3,
    parameter logic [7:0]  PRODUCT_ID = 8'h06
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [7:0]                 addr,
    input  logic [7:0]                 wdata,
    input  logic                       wr_en,
    input  logic                       rd_en,
    output logic [7:0]                 rdata,
    input  logic [NUM_CH-1:0]          upd_valid,
    input  logic [NUM_CH*8-1:0]        upd_hi,
    input  logic [NUM_CH*8-1:0]        upd_lo,
    input  logic                       stat_we,
    input  logic [7:0]                 stat_in,
    output logic [7:0]                 cfg_out,
    output logic [(NUM_CH-1)*8-1:0]    corr_out,
    output logic                       conv_req
);

    localparam int unsigned NUM_REMOTE = NUM_CH - 1;

    logic [NUM_CH-1:0][DW-1:0] live_hi;
    logic [NUM_CH-1:0][DW-1:0] hold_lo;
    logic [DW-1:0]             status;
    logic [DW-1:0]             rdata_d, rdata_q;

    for (genvar c = 0; c < int'(NUM_CH); c++) begin : g_chan
        localparam logic [7:0] HI_ADDR = A_TEMP_BASE + 8'(2 * c);
        sensbank_chan u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .upd_valid (upd_valid[c]),
            .upd_hi    (upd_hi[c*DW +: DW]),
            .upd_lo    (upd_lo[c*DW +: DW]),
            .cap       (rd_en && (addr == HI_ADDR)),
            .live_hi   (live_hi[c]),
            .hold_lo   (hold_lo[c])
        );
    end

    sensbank_ctl #(.NUM_REMOTE(NUM_REMOTE)) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .wdata    (wdata),
        .wr_en    (wr_en),
        .stat_we  (stat_we),
        .stat_in  (stat_in),
        .cfg      (cfg_out),
        .status   (status),
        .corr     (corr_out),
        .conv_req (conv_req)
    );

    always_comb begin
        rdata_d = rdata_q;
        if (rd_en) begin
            rdata_d = '0;
            if (addr == A_STATUS) rdata_d = status;
            if (addr == A_CFG_RD) rdata_d = cfg_out;
            if (addr == A_PID)    rdata_d = PRODUCT_ID;
            if (addr == A_MID)    rdata_d = MID_VAL;
            if (addr == A_REV)    rdata_d = REV_VAL;
            for (int c = 0; c < int'(NUM_CH); c++) begin
                if (addr == A_TEMP_BASE + 8'(2 * c))     rdata_d = live_hi[c];
                if (addr == A_TEMP_BASE + 8'(2 * c + 1)) rdata_d = hold_lo[c];
            end
            for (int r = 0; r < int'(NUM_REMOTE); r++) begin
                if (addr == A_CORR_BASE + 8'(r)) rdata_d = corr_out[r*DW +: DW];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/sensbank_chk.sv
module sensbank_chk #(
    parameter int unsigned NUM_REMOTE = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [7:0]               addr,
    input logic [7:0]               wdata,
    input logic                     wr_en,
    input logic                     rd_en,
    input logic [7:0]               rdata,
    input logic [7:0]               cfg_out,
    input logic [NUM_REMOTE*8-1:0]  corr_out,
    input logic                     conv_req
);

    p_oneshot_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |-> $past(wr_en && addr == 8'h0F));

    p_oneshot_fire_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 8'h0F) |=> conv_req);

    p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_en) |-> $stable(rdata));

    p_cfg_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 8'h09) |=> (cfg_out == $past(wdata)));

    p_cfg_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en && addr == 8'h09) |-> $stable(cfg_out));

    p_corr_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en && (addr == 8'h27 || addr == 8'h28)) |-> $stable(corr_out));

    p_mid_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 8'hFE) |=> (rdata == 8'h5D));

    p_unmapped_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (addr == 8'h00 || addr == 8'h09 || addr == 8'h0F)) |=> (rdata == 8'h00));

endmodule

bind sensbank_top sensbank_chk #(.NUM_REMOTE(NUM_CH - 1)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .wdata    (wdata),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .rdata    (rdata),
    .cfg_out  (cfg_out),
    .corr_out (corr_out),
    .conv_req (conv_req)
);

// File: tb/tb_sensbank_top.sv
module tb_sensbank_top;

    localparam int         NCH = 3;
    localparam logic [7:0] PID = 8'h06;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] addr = '0, wdata = '0, stat_in = '0;
    logic wr_en = 1'b0, rd_en = 1'b0, stat_we = 1'b0;
    logic [NCH-1:0] upd_valid = '0;
    logic [NCH*8-1:0] upd_hi = '0, upd_lo = '0;
    logic [7:0] rdata, cfg_out;
    logic [(NCH-1)*8-1:0] corr_out;
    logic conv_req;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // bench model of visible state
    logic [7:0] m_cfg, m_stat;
    logic [7:0] m_corr [2];
    logic [7:0] m_hi [NCH];
    logic [7:0] m_lo [NCH];
    logic [7:0] m_hold [NCH];

    always #2 clk = ~clk;

    sensbank_top #(.NUM_CH(NCH), .PRODUCT_ID(PID)) dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
        .rd_en(rd_en), .rdata(rdata), .upd_valid(upd_valid), .upd_hi(upd_hi),
        .upd_lo(upd_lo), .stat_we(stat_we), .stat_in(stat_in),
        .cfg_out(cfg_out), .corr_out(corr_out), .conv_req(conv_req)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(input logic [7:0] a);
        logic [7:0] v = 8'h00;
        if (a == 8'h02) v = m_stat;
        if (a == 8'h03) v = m_cfg;
        if (a == 8'h27) v = m_corr[0];
        if (a == 8'h28) v = m_corr[1];
        if (a == 8'hFD) v = PID;
        if (a == 8'hFE) v = 8'h5D;
        if (a == 8'hFF) v = 8'h01;
        for (int c = 0; c < NCH; c++) begin
            if (a == 8'(8'h10 + 2*c))     v = m_hi[c];
            if (a == 8'(8'h10 + 2*c + 1)) v = m_hold[c];
        end
        return v;
    endfunction

    function automatic bit is_hi(input logic [7:0] a, output int ch);
        ch = 0;
        for (int c = 0; c < NCH; c++) if (a == 8'(8'h10 + 2*c)) begin ch = c; return 1'b1; end
        return 1'b0;
    endfunction

    // read: model captures on high-byte address before any same-cycle update
    task automatic do_read(input logic [7:0] a, output logic [7:0] got, output logic [7:0] exp);
        int ch;
        exp = exp_rd(a);
        if (is_hi(a, ch)) m_hold[ch] = m_lo[ch];
        addr = a; rd_en = 1'b1;
        @(posedge clk); @(negedge clk);
        rd_en = 1'b0;
        got = rdata;
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d);
        if (a == 8'h09) m_cfg = d;
        if (a == 8'h27) m_corr[0] = d;
        if (a == 8'h28) m_corr[1] = d;
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic push(input int ch, input logic [7:0] h, input logic [7:0] l);
        upd_valid[ch] = 1'b1;
        upd_hi[ch*8 +: 8] = h;
        upd_lo[ch*8 +: 8] = l;
        m_hi[ch] = h; m_lo[ch] = l;
        @(posedge clk); @(negedge clk);
        upd_valid = '0;
    endtask

    task automatic sweep(input string req);
        logic [7:0] g, e;
        for (int a = 0; a < 256; a++) begin
            do_read(8'(a), g, e);
            chk(req, g, e);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%02h expected=%02h", 8'h00, 8'h01);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] g, e;
        m_cfg = 0; m_stat = 0; m_corr[0] = 8'h12; m_corr[1] = 8'h12;
        for (int c = 0; c < NCH; c++) begin m_hi[c] = 0; m_lo[c] = 0; m_hold[c] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state at the ports
        chk("R1 rdata", rdata, 8'h00);
        chk("R1 cfg_out", cfg_out, 8'h00);
        chk("R1 corr1", corr_out[7:0], 8'h12);
        chk("R1 corr2", corr_out[15:8], 8'h12);
        chk("R9 idle conv_req", {7'b0, conv_req}, 8'h00);
        // R1 R2 R11 full sweep of defaults
        sweep("R1/R2/R11 default sweep");

        // R3 R8 R11 stray writes everywhere not writable
        for (int a = 0; a < 256; a++) begin
            if (a != 8'h09 && a != 8'h27 && a != 8'h28 && a != 8'h0F) do_write(8'(a), 8'hA5);
        end
        chk("R3 cfg_out after stray writes", cfg_out, 8'h00);
        chk("R3 corr after stray writes", corr_out[7:0], 8'h12);
        chk("R3 no conv_req", {7'b0, conv_req}, 8'h00);
        sweep("R3/R11 sweep after stray writes");

        // R9 one-shot
        addr = 8'h0F; wdata = 8'hFF; wr_en = 1'b1;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
        chk("R9 conv_req high", {7'b0, conv_req}, 8'h01);
        @(negedge clk);
        chk("R9 conv_req one cycle", {7'b0, conv_req}, 8'h00);
        do_read(8'h0F, g, e); chk("R9 one-shot not readable", g, 8'h00);

        // R7 split config addresses
        do_write(8'h09, 8'h81);
        chk("R7 cfg_out", cfg_out, 8'h81);
        do_read(8'h03, g, e); chk("R7 read at 03h", g, 8'h81);
        do_read(8'h09, g, e); chk("R2 read at 09h", g, 8'h00);
        do_write(8'h03, 8'h22);
        chk("R3 write at 03h ignored", cfg_out, 8'h81);

        // R10 correction factors
        do_write(8'h27, 8'h55);
        do_write(8'h28, 8'hAA);
        do_read(8'h27, g, e); chk("R10 corr1 read", g, 8'h55);
        do_read(8'h28, g, e); chk("R10 corr2 read", g, 8'hAA);
        chk("R10 corr_out", corr_out[7:0], 8'h55);
        chk("R10 corr_out2", corr_out[15:8], 8'hAA);

        // R8 status
        stat_in = 8'h3C; stat_we = 1'b1; m_stat = 8'h3C;
        @(posedge clk); @(negedge clk);
        stat_we = 1'b0;
        do_read(8'h02, g, e); chk("R8 status load", g, 8'h3C);
        do_write(8'h02, 8'hFF);
        do_read(8'h02, g, e); chk("R8 status host write ignored", g, 8'h3C);

        // load distinct readings per channel
        for (int c = 0; c < NCH; c++) push(c, 8'(8'h20 + 16*c), 8'(8'h01 + c));

        // R5 low before high: stale holding content, no capture
        for (int c = 0; c < NCH; c++) begin
            do_read(8'(8'h11 + 2*c), g, e); chk("R5 low first stale", g, 8'h00);
            do_read(8'(8'h11 + 2*c), g, e); chk("R5 low read does not capture", g, 8'h00);
        end

        // R4 high then update then low
        for (int c = 0; c < NCH; c++) begin
            do_read(8'(8'h10 + 2*c), g, e); chk("R4 high live", g, 8'(8'h20 + 16*c));
            push(c, 8'(8'h90 + c), 8'(8'hC0 + c));
            do_read(8'(8'h11 + 2*c), g, e); chk("R4 low frozen", g, 8'(8'h01 + c));
            do_read(8'(8'h10 + 2*c), g, e); chk("R4 new high", g, 8'(8'h90 + c));
            do_read(8'(8'h11 + 2*c), g, e); chk("R4 new low", g, 8'(8'hC0 + c));
        end

        // R6 update and high read in the same cycle
        for (int c = 0; c < NCH; c++) begin
            addr = 8'(8'h10 + 2*c); rd_en = 1'b1;
            upd_valid[c] = 1'b1; upd_hi[c*8 +: 8] = 8'h77; upd_lo[c*8 +: 8] = 8'h66;
            @(posedge clk); @(negedge clk);
            rd_en = 1'b0; upd_valid = '0;
            chk("R6 high pre-update", rdata, 8'(8'h90 + c));
            m_hold[c] = m_lo[c]; m_hi[c] = 8'h77; m_lo[c] = 8'h66;
            do_read(8'(8'h11 + 2*c), g, e); chk("R6 low pre-update", g, 8'(8'hC0 + c));
        end

        // R12 rdata holds while no read
        do_read(8'hFD, g, e); chk("R11 product id", g, PID);
        repeat (4) @(negedge clk);
        chk("R12 rdata held", rdata, PID);

        // final coherent sweep against model
        sweep("R2/R4 final sweep");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule